// File: doc/BRIEF.md
# Down-Counting Event Timer with One-Shot and Periodic Modes

This block is an event timer that counts ticks from an external microsecond timebase. Software arms it with a single write to its value register. That one write sets the start count, the periodic-mode bit and the enable bit together. While it is enabled, the timer decrements once per tick. When its count expires it raises a level interrupt.

In one-shot mode the timer disarms itself after the first expiry. In periodic mode it reloads the programmed count and keeps running. A programmed count of n produces an expiry every n+1 ticks, so a period of P ticks is programmed as P-1. The interrupt stays high until software writes a 1 to bit 0 of a separate clear register.

The register port is a plain write strobe with a one-bit address. Address 0 is the value register and address 1 is the clear register. The read data is combinational and follows the address input.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset the interrupt is low, the value register reads 0 and the clear register reads 0.
- R2: A write to address 0 loads three fields at once: bit 31 is enable, bit 30 is periodic mode and bits 28:0 are the count. Reading address 0 returns enable in bit 31, periodic in bit 30, 0 in bit 29 and the remaining count in bits 28:0.
- R3: In one-shot mode a written count n raises the interrupt on the (n+1)-th tick after the write, and not earlier.
- R4: On a one-shot expiry the enable bit clears itself and the remaining count stays at 0. Later ticks raise no new expiry.
- R5: In periodic mode every expiry reloads the written count, and the interrupt is raised again every n+1 ticks.
- R6: Writing 0 to the value register stops the timer. Ticks then change neither the count nor the interrupt.
- R7: The interrupt is an active-high level. It falls only when address 1 is written with bit 0 set. A write to address 1 with bit 0 clear has no effect.
- R8: If an expiry and a clear write occur in the same cycle, the interrupt stays high.
- R9: A write to address 0 while the timer is running restarts the count from the new value, and this write takes precedence over a tick in the same cycle. A pending interrupt is not affected by the write.
- R10: The count changes only in cycles where the tick input is high.
- R11: Reading address 1 returns the interrupt level in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle pulse per microsecond tick from the timebase |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the value register, 1 selects the clear register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the register selected by regAddr |
| irq | output | 1 | Level interrupt, active high |

## Verification
Every write and every tick acts at the clock edge that samples it. The readback and the interrupt show the new state combinationally one edge after the stimulus, so an expiry on the (n+1)-th tick is visible just after that tick's edge. The bench drives its inputs on the falling edge and steps a reference model at the rising edge. It samples 1 ns after that edge and compares both the interrupt and the read data on every cycle. Directed sequences count their ticks explicitly, so each expiry is checked against the exact edge on which it is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 32;
  localparam int EN_POS  = 31;
  localparam int PER_POS = 30;

  typedef struct packed {
    logic loadCfg;
    logic reloadCnt;
    logic decCnt;
    logic stopRun;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       valWr,
  input  logic       clrWr,
  input  logic       runEn,
  input  logic       perMode,
  input  logic       remZero,
  output tmrStrobe_t strobe,
  output logic       irq
);
  logic expire;

  // A write to the value register suppresses the tick in the same cycle.
  assign expire = runEn && tickEn && remZero && !valWr;

  always_comb begin
    strobe.loadCfg   = valWr;
    strobe.reloadCnt = expire && perMode;
    strobe.stopRun   = expire && !perMode;
    strobe.decCnt    = runEn && tickEn && !remZero && !valWr;
  end

  // An expiry takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       irq <= 1'b0;
    else if (expire) irq <= 1'b1;
    else if (clrWr)  irq <= 1'b0;
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic             wrEn,
  input  logic             wrPer,
  input  logic [CNT_W-1:0] wrCnt,
  output logic             runEn,
  output logic             perMode,
  output logic [CNT_W-1:0] remCnt,
  output logic             remZero
);
  logic [CNT_W-1:0] reloadVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      perMode   <= 1'b0;
      reloadVal <= '0;
      remCnt    <= '0;
    end else if (strobe.loadCfg) begin
      runEn     <= wrEn;
      perMode   <= wrPer;
      reloadVal <= wrCnt;
      remCnt    <= wrCnt;
    end else if (strobe.reloadCnt) begin
      remCnt <= reloadVal;
    end else if (strobe.stopRun) begin
      runEn <= 1'b0;
    end else if (strobe.decCnt) begin
      remCnt <= remCnt - 1'b1;
    end
  end

  assign remZero = (remCnt == '0);
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);
  localparam int PAD_W = PER_POS - CNT_W;

  tmrStrobe_t       strobe;
  logic             valWr, clrWr;
  logic             runEn, perMode, remZero;
  logic [CNT_W-1:0] remCnt;
  logic [DATA_W-1:0] valView;

  assign valWr = regWe && (regAddr == 1'b0);
  assign clrWr = regWe && (regAddr == 1'b1) && regWdata[0];

  tmr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .valWr(valWr), .clrWr(clrWr),
    .runEn(runEn), .perMode(perMode), .remZero(remZero),
    .strobe(strobe), .irq(irq)
  );

  tmr_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrEn(regWdata[EN_POS]), .wrPer(regWdata[PER_POS]),
    .wrCnt(regWdata[CNT_W-1:0]),
    .runEn(runEn), .perMode(perMode), .remCnt(remCnt), .remZero(remZero)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign valView = {runEn, perMode, {PAD_W{1'b0}}, remCnt};
    end else begin : g_nopad
      assign valView = {runEn, perMode, remCnt};
    end
  endgenerate

  assign regRdata = regAddr ? {{(DATA_W-1){1'b0}}, irq} : valView;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             regWe,
  input logic             regAddr,
  input logic [31:0]      regWdata,
  input logic             irq,
  input logic             runEn,
  input logic             perMode,
  input logic [CNT_W-1:0] remCnt
);
  logic valW, clrW, expNow;
  assign valW   = regWe && !regAddr;
  assign clrW   = regWe && regAddr && regWdata[0];
  assign expNow = runEn && tickEn && (remCnt == '0) && !valW;

  // R2: a value write loads the count field
  a_r2_load_count: assert property (@(posedge clk) disable iff (!rstN)
    valW |=> remCnt == $past(regWdata[CNT_W-1:0]));

  // R4: one-shot expiry disarms the timer
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (expNow && !perMode) |=> !runEn);

  // R7: the interrupt holds until a clear write
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrW) |=> irq);

  // R8: an expiry always leaves the interrupt high, even with a clear
  a_r8_expiry_wins: assert property (@(posedge clk) disable iff (!rstN)
    expNow |=> irq);

  // R10: without a tick or a write, the count does not move
  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !valW) |=> $stable(remCnt));
endmodule

bind tick_alarm_timer tmr_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .irq(irq), .runEn(runEn), .perMode(perMode),
  .remCnt(remCnt)
);

// File: tb/tick_alarm_timer_tb.sv
module tick_alarm_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWe = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;

  int nChecks = 0;
  int nErrs = 0;
  bit done = 0;

  // reference model state
  logic        mEn = 0, mPer = 0, mIrq = 0;
  logic [28:0] mReload = '0, mRem = '0;

  always #5 clk = ~clk;

  tick_alarm_timer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  function automatic logic [31:0] expRd(input logic addr);
    return addr ? {31'b0, mIrq} : {mEn, mPer, 1'b0, mRem};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic we, input logic addr, input logic [31:0] wd,
                           input logic tk);
    logic vw, cw, ex;
    vw = we && !addr;
    cw = we && addr && wd[0];
    ex = mEn && tk && (mRem == 0) && !vw;
    if (ex) mIrq = 1;
    else if (cw) mIrq = 0;
    if (vw) begin
      mEn = wd[31]; mPer = wd[30]; mReload = wd[28:0]; mRem = wd[28:0];
    end else if (ex) begin
      if (mPer) mRem = mReload;
      else mEn = 0;
    end else if (mEn && tk) begin
      mRem = mRem - 1;
    end
  endtask

  task automatic step(input logic we, input logic addr, input logic [31:0] wd,
                      input logic tk);
    @(negedge clk);
    regWe = we; regAddr = addr; regWdata = wd; tickEn = tk;
    @(posedge clk);
    modelStep(we, addr, wd, tk);
    #1;
    chk("model R3 R5 R7 R9 irq", {31'b0, irq}, {31'b0, mIrq});
    chk("model R2 R11 rdata", regRdata, expRd(addr));
    @(negedge clk);
    regWe = 0; tickEn = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nErrs++; nChecks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 value reg after reset", regRdata, 0);
    regAddr = 1; #1;
    chk("R1 clear reg after reset", regRdata, 0);
    regAddr = 0;
    @(negedge clk); rstN = 1;

    // R2 readback of fields
    step(1, 0, 32'hA000_0005, 0);   // bit 29 written as 1 must read 0
    chk("R2 field readback", regRdata, 32'h8000_0005);
    // R10 no tick keeps count
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk("R10 count holds without tick", regRdata, 32'h8000_0005);
    // R3 one-shot n=3: fires on 4th tick
    step(1, 0, 32'h8000_0003, 0);
    ticks(3);
    chk("R3 no irq after n ticks", {31'b0, irq}, 0);
    ticks(1);
    chk("R3 irq on tick n+1", {31'b0, irq}, 1);
    chk("R4 enable self-clears", regRdata, 32'h0000_0000);
    ticks(5);
    chk("R4 stays stopped", regRdata, 32'h0000_0000);
    // R7 clear with bit0=0 has no effect, then real clear
    step(1, 1, 32'hFFFF_FFFE, 0);
    chk("R7 clear bit0=0 ignored", {31'b0, irq}, 1);
    chk("R11 clear reg shows irq", regRdata, 1);
    step(1, 1, 32'h1, 0);
    chk("R7 clear drops irq", {31'b0, irq}, 0);
    // R5 periodic n=2
    step(1, 0, 32'hC000_0002, 0);
    ticks(3);
    chk("R5 first periodic expiry", {31'b0, irq}, 1);
    chk("R5 reload after expiry", regRdata, 32'hC000_0002);
    step(1, 1, 1, 0);
    ticks(2);
    chk("R5 no early second expiry", {31'b0, irq}, 0);
    ticks(1);
    chk("R5 second periodic expiry", {31'b0, irq}, 1);
    // R8 expiry and clear in same cycle
    step(1, 0, 32'hC000_0000, 0);
    step(1, 1, 1, 1);
    chk("R8 expiry wins over clear", {31'b0, irq}, 1);
    // R9 restart while running, irq pending
    step(1, 0, 32'h8000_0009, 0);
    ticks(2);
    step(1, 0, 32'h8000_0007, 1);
    chk("R9 restart from new value", regRdata, 32'h8000_0007);
    chk("R9 pending irq kept", {31'b0, irq}, 1);
    // R6 write zero stops
    step(1, 1, 1, 0);
    step(1, 0, 32'h0, 0);
    ticks(20);
    chk("R6 stopped count", regRdata, 0);
    chk("R6 no irq when stopped", {31'b0, irq}, 0);

    // constrained random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic we, ad, tk;
      logic [31:0] wd;
      we = ($urandom_range(0, 9) == 0);
      ad = $urandom_range(0, 1);
      tk = $urandom_range(0, 1);
      wd = {$urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1'b0,
            29'($urandom_range(0, 12))};
      if (ad) wd = {31'b0, $urandom_range(0, 1) == 1};
      step(we, ad, wd, tk);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end
endmodule